// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block steers operand bypassing in a five-stage in-order pipeline. It looks at the two source register indices of the instruction in the execute stage. It compares them with the destination index and write flag of the instructions one stage and two stages further on, in memory access and in writeback. For each source operand it returns a select code. The code tells the external data multiplexer to take the register-file value read in decode, the result held in the memory stage, or the result held in writeback.

It also raises a stall request when the memory-stage instruction is a load whose result is needed by the execute stage. That value only becomes available one cycle too late to forward. The decision rests only on register indices and write enables. No opcode decoding is done, so an instruction that does not use a source field still receives a select for it.

The block is purely combinational. The data path, the register file, the stall and flush sequencing and the branch logic sit around it.

Top module: `opnd_bypass_ctrl`

## Requirements
- R1: Each select output uses the code 2'b00 for the decode-stage register-file value, 2'b01 for the memory-stage result and 2'b10 for the writeback-stage result; 2'b11 never appears.
- R2: When no later stage holds a matching destination, both selects are 2'b00 and `ld_stall_req` is 0 (this includes the all-zero input state after reset).
- R3: When the memory-stage destination equals a source index, the memory write flag is 1 and the index is not 0, that operand's select is 2'b01.
- R4: When only the writeback-stage destination matches a source index with its write flag 1 and a nonzero index, that operand's select is 2'b10.
- R5: When both later stages match the same source index, the memory stage wins (select 2'b01).
- R6: A stage whose write flag is 0 is never forwarded from, even if its destination index matches.
- R7: Index 0 is never forwarded and never causes a stall, whatever the write flags are.
- R8: Both operands are resolved independently, and a select is produced whenever indices match, with no regard to whether the instruction reads that operand.
- R9: `ld_stall_req` is 1 exactly when the memory-stage instruction has its write flag and load flag set and a nonzero destination equal to either source index. While it is 1, the select of the matching operand is unspecified.
- R10: An instruction with its memory-stage write flag at 0, such as a store, never raises `ld_stall_req`, even if its load flag is set.
- R11: A load that has reached writeback raises no stall and is forwarded with select 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a_idx | input | IDX_W | First source register index of the execute-stage instruction |
| ex_src_b_idx | input | IDX_W | Second source register index of the execute-stage instruction |
| mem_dst_idx | input | IDX_W | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| wb_dst_idx | input | IDX_W | Destination index of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| fwd_sel_a | output | 2 | Source select for the first operand |
| fwd_sel_b | output | 2 | Source select for the second operand |
| ld_stall_req | output | 1 | Request to hold the pipeline for one load-use cycle |

## Verification
The bench builds the block with its default index width of five bits and two source operands. This width lets it drive both ends of the register range: index 0, which must never be bypassed or stall, and index 31. Vectors cover matches in both stages at once, matches gated off by a low write flag, loads that hit either operand, loads that have already reached writeback, and a store that carries a stray load flag.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMSTG  = 2'b01,
    SRC_WBSTG   = 2'b10
  } byp_src_e;

endpackage

// File: rtl/byp_stage_match.sv
module byp_stage_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             dst_wr,
  output logic             hit
);

  logic idx_eq;
  logic dst_zero;

  always_comb begin
    idx_eq   = (src_idx == dst_idx);
    dst_zero = (dst_idx == '0);
    hit      = dst_wr && idx_eq && !dst_zero;
    if (src_idx == '0) begin
      AST_ZERO_IDX_NO_HIT: assert (!hit); // R7
    end
    if (!dst_wr) begin
      AST_NOWR_NO_HIT: assert (!hit); // R6
    end
  end

endmodule

// File: rtl/byp_src_pick.sv
module byp_src_pick
  import opnd_bypass_pkg::*;
(
  input  logic       mem_hit,
  input  logic       wb_hit,
  output logic [1:0] sel
);

  byp_src_e pick;

  always_comb begin
    if (mem_hit) begin
      pick = SRC_MEMSTG;
    end else if (wb_hit) begin
      pick = SRC_WBSTG;
    end else begin
      pick = SRC_REGFILE;
    end
    sel = pick;
    AST_SEL_LEGAL: assert (sel != 2'b11); // R1
    if (mem_hit && wb_hit) begin
      AST_MEM_PRIO: assert (sel == 2'b01); // R5
    end
    if (!mem_hit && !wb_hit) begin
      AST_DEFAULT_REGFILE: assert (sel == 2'b00); // R2
    end
  end

endmodule

// File: rtl/byp_load_guard.sv
module byp_load_guard #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0]              mem_dst_idx,
  input  logic                          mem_wr_en,
  input  logic                          mem_is_load,
  output logic                          stall
);

  logic [NUM_SRC-1:0] use_hit;
  logic               load_wr;

  always_comb begin
    load_wr = mem_wr_en && mem_is_load && (mem_dst_idx != '0);
    for (int i = 0; i < NUM_SRC; i++) begin
      use_hit[i] = load_wr && (src_idx[i] == mem_dst_idx);
    end
    stall = |use_hit;
    if (!mem_wr_en) begin
      AST_STORE_NO_STALL: assert (!stall); // R10
    end
    if (!mem_is_load) begin
      AST_NONLOAD_NO_STALL: assert (!stall); // R9
    end
  end

endmodule

// File: rtl/opnd_bypass_ctrl.sv
module opnd_bypass_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_src_a_idx,
  input  logic [IDX_W-1:0] ex_src_b_idx,
  input  logic [IDX_W-1:0] mem_dst_idx,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [IDX_W-1:0] wb_dst_idx,
  input  logic             wb_wr_en,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b,
  output logic             ld_stall_req
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][IDX_W-1:0] src_vec;
  logic [NUM_SRC-1:0][1:0]       sel_vec;
  logic [NUM_SRC-1:0]            mem_hit;
  logic [NUM_SRC-1:0]            wb_hit;

  assign src_vec[0] = ex_src_a_idx;
  assign src_vec[1] = ex_src_b_idx;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    byp_stage_match #(.IDX_W(IDX_W)) i_mem_match (
      .src_idx (src_vec[g]),
      .dst_idx (mem_dst_idx),
      .dst_wr  (mem_wr_en),
      .hit     (mem_hit[g])
    );

    byp_stage_match #(.IDX_W(IDX_W)) i_wb_match (
      .src_idx (src_vec[g]),
      .dst_idx (wb_dst_idx),
      .dst_wr  (wb_wr_en),
      .hit     (wb_hit[g])
    );

    byp_src_pick i_pick (
      .mem_hit (mem_hit[g]),
      .wb_hit  (wb_hit[g]),
      .sel     (sel_vec[g])
    );
  end

  byp_load_guard #(
    .IDX_W   (IDX_W),
    .NUM_SRC (NUM_SRC)
  ) i_load_guard (
    .src_idx     (src_vec),
    .mem_dst_idx (mem_dst_idx),
    .mem_wr_en   (mem_wr_en),
    .mem_is_load (mem_is_load),
    .stall       (ld_stall_req)
  );

  assign fwd_sel_a = sel_vec[0];
  assign fwd_sel_b = sel_vec[1];

endmodule

// File: tb/test_opnd_bypass_ctrl.sv
module test_opnd_bypass_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 5;
  localparam int WDOG_CYC   = 2000;

  typedef struct {
    logic [1:0] sel_a;
    logic [1:0] sel_b;
    logic       stall;
    logic       chk_sel;
    string      req;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [IDX_W-1:0] ex_src_a_idx, ex_src_b_idx, mem_dst_idx, wb_dst_idx;
  logic             mem_wr_en, mem_is_load, wb_wr_en;
  logic [1:0]       fwd_sel_a, fwd_sel_b;
  logic             ld_stall_req;

  exp_t exp_q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   done     = 0;

  opnd_bypass_ctrl #(.IDX_W(IDX_W)) i_opnd_bypass_ctrl (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .mem_dst_idx  (mem_dst_idx),
    .mem_wr_en    (mem_wr_en),
    .mem_is_load  (mem_is_load),
    .wb_dst_idx   (wb_dst_idx),
    .wb_wr_en     (wb_wr_en),
    .fwd_sel_a    (fwd_sel_a),
    .fwd_sel_b    (fwd_sel_b),
    .ld_stall_req (ld_stall_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input int a, input int b, input int mrd, input bit mwr,
                       input bit mld, input int wrd, input bit wwr,
                       input logic [1:0] ea, input logic [1:0] eb, input bit est,
                       input bit csel, input string req);
    exp_t e;
    @(negedge clk);
    ex_src_a_idx = IDX_W'(a);
    ex_src_b_idx = IDX_W'(b);
    mem_dst_idx  = IDX_W'(mrd);
    mem_wr_en    = mwr;
    mem_is_load  = mld;
    wb_dst_idx   = IDX_W'(wrd);
    wb_wr_en     = wwr;
    e.sel_a = ea; e.sel_b = eb; e.stall = est; e.chk_sel = csel; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (ld_stall_req !== e.stall) begin
        failures++;
        $display("FAIL %s stall act=%0b exp=%0b", e.req, ld_stall_req, e.stall);
      end
      if (e.chk_sel) begin
        checks++;
        if (fwd_sel_a !== e.sel_a || fwd_sel_b !== e.sel_b) begin
          failures++;
          $display("FAIL %s sel act=%b/%b exp=%b/%b", e.req, fwd_sel_a, fwd_sel_b,
                   e.sel_a, e.sel_b);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    ex_src_a_idx = '0; ex_src_b_idx = '0; mem_dst_idx = '0; wb_dst_idx = '0;
    mem_wr_en = 1'b0; mem_is_load = 1'b0; wb_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2 reset state: all inputs zero
    drive(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 0, 1, "R2_reset");
    // R6 mem matches a but write off; R4 wb matches b
    drive(4, 5, 4, 0, 0, 5, 1, 2'b00, 2'b10, 0, 1, "R6_R4");
    // R3 mem match on a, non-load
    drive(3, 7, 3, 1, 0, 9, 0, 2'b01, 2'b00, 0, 1, "R3");
    // R5 both stages match both operands
    drive(9, 9, 9, 1, 0, 9, 1, 2'b01, 2'b01, 0, 1, "R5");
    // R7 index zero everywhere, writes on
    drive(0, 0, 0, 1, 1, 0, 1, 2'b00, 2'b00, 0, 1, "R7");
    // R9 load in mem hits a
    drive(6, 2, 6, 1, 1, 0, 0, 2'b00, 2'b00, 1, 0, "R9_a");
    // R9 load in mem hits b
    drive(1, 8, 8, 1, 1, 0, 0, 2'b00, 2'b00, 1, 0, "R9_b");
    // R9 load in mem, no index match
    drive(1, 2, 5, 1, 1, 0, 0, 2'b00, 2'b00, 0, 1, "R9_nomatch");
    // R10 store with stray load flag and matching index
    drive(6, 3, 6, 0, 1, 0, 0, 2'b00, 2'b00, 0, 1, "R10");
    // R11 load already in writeback
    drive(6, 4, 2, 0, 0, 6, 1, 2'b10, 2'b00, 0, 1, "R11");
    // R8 both operands same index from wb
    drive(12, 12, 3, 1, 0, 12, 1, 2'b10, 2'b10, 0, 1, "R8_same");
    // R8 independent operands, different sources
    drive(12, 13, 13, 1, 0, 12, 1, 2'b10, 2'b01, 0, 1, "R8_split");
    // R6 wb match with write off
    drive(14, 15, 1, 1, 0, 14, 0, 2'b00, 2'b00, 0, 1, "R6_wb");
    // R1 top index, both codes
    drive(31, 30, 31, 1, 0, 30, 1, 2'b01, 2'b10, 0, 1, "R1_maxidx");
    // R7 load to x0 with zero source: no stall
    drive(0, 5, 0, 1, 1, 0, 1, 2'b00, 2'b00, 0, 1, "R7_load0");
    // R5 load in mem and wb match same: stall, sel unspecified
    drive(20, 21, 20, 1, 1, 20, 1, 2'b00, 2'b00, 1, 0, "R9_prio");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule